// File: doc/BRIEF.md
# Virtual-Time Invalidate Scheduler

This block sits beside one processor node of an optimistically synchronised shared-memory system. It keeps the node's local virtual time and applies invalidates from remote writers in timestamp order, whatever order the network delivers them in. It also stamps the invalidates that the node's own writes send out.

Each incoming message carries a target address and the virtual time of the remote write. If that stamp is behind the local clock, the block issues a rollback request carrying the stamp and pulls the local clock back to it. If the stamp is ahead, the message waits in a small pending list sorted by stamp until the local clock catches up. Every accepted message goes into the pending list. An entry leaves the list as a local invalidate once its stamp is no later than the local clock. The block does not restore processor state itself and has no cache array or network transport. A rollback request tells the rest of the node where to restore to.

Top module: `tstamp_inval_sched`

## Requirements
- R1: After reset the local time is 0, no invalidate, rollback or outgoing stamp is valid, and `in_ready_o` is 1.
- R2: When no rollback occurs, the local time increases by exactly 1 at each clock edge where `adv_i` is 1, and holds otherwise.
- R3: A local write (`lw_valid_i`) gives, one edge later, `out_valid_o`=1 with its address and with `out_stamp_o` equal to the local time during the write cycle.
- R4: An accepted message with stamp strictly below the local time gives a one-cycle `rb_valid_o` pulse with `rb_stamp_o` equal to that stamp, and sets the local time to the stamp; this overrides `adv_i` in the same cycle. The message's own invalidate follows on the next cycle.
- R5: An accepted message whose stamp equals the local time causes no rollback, and its invalidate appears two edges after acceptance when no older entry is pending.
- R6: A message with a later stamp produces no invalidate while the local time is below its stamp. It is released at the first edge where the local time, as held before that edge, is at least its stamp.
- R7: At most one invalidate is released per cycle, and it is always the pending entry with the lowest stamp. Equal stamps leave in arrival order.
- R8: The pending list holds 8 entries, and `in_ready_o` is 0 while it is full. A message offered while `in_ready_o` is 0 is dropped and never issued.
- R9: A rollback discards no pending entry. Entries stamped later than the restored time are still issued once the time reaches them again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Advance local time by one this cycle |
| lw_valid_i | input | 1 | Local write occurs this cycle |
| lw_addr_i | input | ADDR_W | Address of the local write |
| in_valid_i | input | 1 | Remote invalidate offered |
| in_addr_i | input | ADDR_W | Remote invalidate target address |
| in_stamp_i | input | TS_W | Remote writer's virtual time |
| in_ready_o | output | 1 | Pending list can take a message |
| inv_valid_o | output | 1 | Apply an invalidate locally this cycle |
| inv_addr_o | output | ADDR_W | Address to invalidate |
| inv_stamp_o | output | TS_W | Stamp of the released invalidate |
| rb_valid_o | output | 1 | Rollback request pulse |
| rb_stamp_o | output | TS_W | Virtual time to roll back to |
| out_valid_o | output | 1 | Outgoing invalidate for a local write |
| out_addr_o | output | ADDR_W | Outgoing invalidate address |
| out_stamp_o | output | TS_W | Outgoing invalidate stamp |
| lvt_o | output | TS_W | Current local virtual time |

## Verification
The hardest case to reach from the ports is several pending entries maturing in the same cycle while the list is full. A stimulus that advances time between arrivals drains each entry as soon as it matures. The bench therefore holds the local time at zero and fills all eight slots with shuffled stamps that include duplicates. It then offers a ninth message against the deasserted ready and steps time one tick per cycle, so mature entries pile up faster than they can leave. The resulting release order shows both the lowest-first rule and the tie rule. A second directed run sends a stale message with a pending future entry already in the list, and with `adv_i` high in the same cycle.

// File: rtl/tis_pkg.sv
package tis_pkg;

  // Relation of an arriving stamp to the local clock.
  typedef enum logic [1:0] {
    MSG_STALE  = 2'd0,
    MSG_NOW    = 2'd1,
    MSG_FUTURE = 2'd2
  } msg_class_e;

  function automatic msg_class_e classify(input logic [63:0] stamp,
                                          input logic [63:0] now);
    if (stamp < now)       return MSG_STALE;
    else if (stamp == now) return MSG_NOW;
    else                   return MSG_FUTURE;
  endfunction

endpackage

// File: rtl/tis_lvt_counter.sv
module tis_lvt_counter #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_i,
  input  logic            load_i,
  input  logic [TS_W-1:0] load_val_i,
  output logic [TS_W-1:0] lvt_o
);

  logic [TS_W-1:0] lvt_q, lvt_d;
  logic            lvt_en;

  always_comb begin
    lvt_en = load_i | adv_i;
    if (load_i) lvt_d = load_val_i;          // rollback wins over advance
    else        lvt_d = lvt_q + TS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvt_q <= '0;
    else if (lvt_en) lvt_q <= lvt_d;
  end

  assign lvt_o = lvt_q;

endmodule

// File: rtl/tis_sorted_queue.sv
module tis_sorted_queue #(
  parameter int DEPTH  = 8,
  parameter int TS_W   = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [TS_W-1:0]   push_stamp_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              pop_i,
  output logic              full_o,
  output logic              head_valid_o,
  output logic [TS_W-1:0]   head_stamp_o,
  output logic [ADDR_W-1:0] head_addr_o
);

  // Valid entries are packed at the low indices, ascending by stamp.
  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [TS_W-1:0]   stp_q [DEPTH];
  logic [TS_W-1:0]   stp_d [DEPTH];
  logic [ADDR_W-1:0] adr_q [DEPTH];
  logic [ADDR_W-1:0] adr_d [DEPTH];

  // Source view extended by one empty slot so the pop shift stays in range.
  logic [DEPTH:0]    src_v;
  logic [TS_W-1:0]   src_s [DEPTH+1];
  logic [ADDR_W-1:0] src_a [DEPTH+1];
  // View after the pop.
  logic [DEPTH-1:0]  pv;
  logic [TS_W-1:0]   ps [DEPTH];
  logic [ADDR_W-1:0] pa [DEPTH];
  // View shifted up by one slot, used where the new entry displaces others.
  logic [DEPTH-1:0]  lv;
  logic [TS_W-1:0]   ls [DEPTH];
  logic [ADDR_W-1:0] la [DEPTH];
  logic [DEPTH-1:0]  keep, keep_prev;
  logic              upd_en;

  always_comb begin
    src_v = {1'b0, vld_q};
    for (int i = 0; i < DEPTH; i++) begin
      src_s[i] = stp_q[i];
      src_a[i] = adr_q[i];
    end
    src_s[DEPTH] = '0;
    src_a[DEPTH] = '0;

    for (int i = 0; i < DEPTH; i++) begin
      pv[i] = pop_i ? src_v[i+1] : src_v[i];
      ps[i] = pop_i ? src_s[i+1] : src_s[i];
      pa[i] = pop_i ? src_a[i+1] : src_a[i];
    end

    // Entries with stamp <= new stamp stay put: ties keep arrival order.
    for (int i = 0; i < DEPTH; i++) keep[i] = pv[i] && (ps[i] <= push_stamp_i);

    keep_prev[0] = 1'b1;
    lv[0] = 1'b0;
    ls[0] = '0;
    la[0] = '0;
    for (int i = 1; i < DEPTH; i++) begin
      keep_prev[i] = keep[i-1];
      lv[i] = pv[i-1];
      ls[i] = ps[i-1];
      la[i] = pa[i-1];
    end

    for (int i = 0; i < DEPTH; i++) begin
      if (!push_i || keep[i]) begin
        vld_d[i] = pv[i];
        stp_d[i] = ps[i];
        adr_d[i] = pa[i];
      end else if (keep_prev[i]) begin
        vld_d[i] = 1'b1;
        stp_d[i] = push_stamp_i;
        adr_d[i] = push_addr_i;
      end else begin
        vld_d[i] = lv[i];
        stp_d[i] = ls[i];
        adr_d[i] = la[i];
      end
    end
    upd_en = push_i | pop_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vld_q <= '0;
    else if (upd_en) vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        stp_q[i] <= stp_d[i];
        adr_q[i] <= adr_d[i];
      end
    end
  end

  assign full_o       = vld_q[DEPTH-1];
  assign head_valid_o = vld_q[0];
  assign head_stamp_o = stp_q[0];
  assign head_addr_o  = adr_q[0];

endmodule

// File: rtl/tstamp_inval_sched.sv
module tstamp_inval_sched #(
  parameter int ADDR_W  = 32,
  parameter int TS_W    = 16,
  parameter int Q_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              lw_valid_i,
  input  logic [ADDR_W-1:0] lw_addr_i,
  input  logic              in_valid_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [TS_W-1:0]   in_stamp_i,
  output logic              in_ready_o,
  output logic              inv_valid_o,
  output logic [ADDR_W-1:0] inv_addr_o,
  output logic [TS_W-1:0]   inv_stamp_o,
  output logic              rb_valid_o,
  output logic [TS_W-1:0]   rb_stamp_o,
  output logic              out_valid_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [TS_W-1:0]   out_stamp_o,
  output logic [TS_W-1:0]   lvt_o
);
  import tis_pkg::*;

  logic              accept, rollback, pop;
  logic              q_full, head_v;
  logic [TS_W-1:0]   head_s, lvt;
  logic [ADDR_W-1:0] head_a;
  msg_class_e        cls;

  tis_lvt_counter #(.TS_W(TS_W)) u_clock (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (adv_i),
    .load_i     (rollback),
    .load_val_i (in_stamp_i),
    .lvt_o      (lvt)
  );

  tis_sorted_queue #(.DEPTH(Q_DEPTH), .TS_W(TS_W), .ADDR_W(ADDR_W)) u_pend (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (accept),
    .push_stamp_i (in_stamp_i),
    .push_addr_i  (in_addr_i),
    .pop_i        (pop),
    .full_o       (q_full),
    .head_valid_o (head_v),
    .head_stamp_o (head_s),
    .head_addr_o  (head_a)
  );

  always_comb begin
    cls      = classify(64'(in_stamp_i), 64'(lvt));
    accept   = in_valid_i && !q_full;
    rollback = accept && (cls == MSG_STALE);
    pop      = head_v && (head_s <= lvt);
  end

  // Registered outputs: valids carry reset, payloads load under enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_valid_o <= 1'b0;
      rb_valid_o  <= 1'b0;
      out_valid_o <= 1'b0;
    end else begin
      inv_valid_o <= pop;
      rb_valid_o  <= rollback;
      out_valid_o <= lw_valid_i;
    end
  end

  always_ff @(posedge clk) begin
    if (pop) begin
      inv_addr_o  <= head_a;
      inv_stamp_o <= head_s;
    end
    if (rollback) rb_stamp_o <= in_stamp_i;
    if (lw_valid_i) begin
      out_addr_o  <= lw_addr_i;
      out_stamp_o <= lvt;
    end
  end

  assign in_ready_o = !q_full;
  assign lvt_o      = lvt;

endmodule

// File: rtl/tis_checker.sv
module tis_checker #(
  parameter int ADDR_W = 32,
  parameter int TS_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv_i,
  input logic              lw_valid_i,
  input logic [ADDR_W-1:0] lw_addr_i,
  input logic              in_valid_i,
  input logic [TS_W-1:0]   in_stamp_i,
  input logic              in_ready_o,
  input logic              inv_valid_o,
  input logic [TS_W-1:0]   inv_stamp_o,
  input logic              rb_valid_o,
  input logic [TS_W-1:0]   rb_stamp_o,
  input logic              out_valid_o,
  input logic [ADDR_W-1:0] out_addr_o,
  input logic [TS_W-1:0]   out_stamp_o,
  input logic [TS_W-1:0]   lvt_o
);

  // Set after the first edge out of reset, so $past never sees reset values.
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r2_time_step: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !rb_valid_o) |-> (lvt_o == $past(lvt_o) + TS_W'($past(adv_i))));

  a_r3_out_stamp: assert property (@(posedge clk) disable iff (!rst_n)
    lw_valid_i |=> (out_valid_o && out_stamp_o == $past(lvt_o)
                    && out_addr_o == $past(lw_addr_i)));

  a_r4_rb_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rb_valid_o) |-> $past(in_valid_i && in_ready_o && (in_stamp_i < lvt_o)));

  a_r4_rb_time: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid_o |-> (lvt_o == rb_stamp_o));

  a_r6_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && inv_valid_o) |-> (inv_stamp_o <= $past(lvt_o)));

  a_r5_no_rb_current: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o && (in_stamp_i >= lvt_o)) |=> !rb_valid_o);

endmodule

bind tstamp_inval_sched tis_checker #(.ADDR_W(ADDR_W), .TS_W(TS_W)) u_tis_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .adv_i       (adv_i),
  .lw_valid_i  (lw_valid_i),
  .lw_addr_i   (lw_addr_i),
  .in_valid_i  (in_valid_i),
  .in_stamp_i  (in_stamp_i),
  .in_ready_o  (in_ready_o),
  .inv_valid_o (inv_valid_o),
  .inv_stamp_o (inv_stamp_o),
  .rb_valid_o  (rb_valid_o),
  .rb_stamp_o  (rb_stamp_o),
  .out_valid_o (out_valid_o),
  .out_addr_o  (out_addr_o),
  .out_stamp_o (out_stamp_o),
  .lvt_o       (lvt_o)
);

// File: tb/tstamp_inval_sched_test.sv
module tstamp_inval_sched_test;
  localparam int AW = 32;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          adv, lw_v, in_v;
  logic [AW-1:0] lw_a, in_a;
  logic [TW-1:0] in_s;
  logic          in_rdy, inv_v, rb_v, out_v;
  logic [AW-1:0] inv_a, out_a;
  logic [TW-1:0] inv_s, rb_s, out_s, lvt;

  int tests = 0;
  int fails = 0;
  int wd    = 0;

  always #10 clk = ~clk;   // 50 MHz

  tstamp_inval_sched #(.ADDR_W(AW), .TS_W(TW), .Q_DEPTH(8)) uut (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .lw_valid_i(lw_v), .lw_addr_i(lw_a),
    .in_valid_i(in_v), .in_addr_i(in_a), .in_stamp_i(in_s), .in_ready_o(in_rdy),
    .inv_valid_o(inv_v), .inv_addr_o(inv_a), .inv_stamp_o(inv_s),
    .rb_valid_o(rb_v), .rb_stamp_o(rb_s), .out_valid_o(out_v), .out_addr_o(out_a),
    .out_stamp_o(out_s), .lvt_o(lvt)
  );

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 20000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", wd);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs, clock it, sample 1 ns after the edge.
  task automatic step(input logic a, input logic iv, input logic [TW-1:0] is,
                      input logic [AW-1:0] ia, input logic w, input logic [AW-1:0] wa);
    adv = a; in_v = iv; in_s = is; in_a = ia; lw_v = w; lw_a = wa;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    adv = 0; in_v = 0; in_s = '0; in_a = '0; lw_v = 0; lw_a = '0;
    rst_n = 0;
    @(posedge clk); @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk);
    #1;
  endtask

  typedef struct packed {
    logic        adv;
    logic        iv;
    logic [15:0] is;
    logic [7:0]  ia;
    logic        lw;
    logic [7:0]  la;
    logic [15:0] e_lvt;
    logic        e_inv;
    logic [7:0]  e_inva;
    logic        e_rb;
    logic [15:0] e_rbs;
    logic        e_out;
    logic [15:0] e_outs;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{1'b1, 1'b0, 16'd0, 8'h00, 1'b0, 8'h00, 16'd1, 1'b0, 8'h00, 1'b0, 16'd0, 1'b0, 16'd0},
    '{1'b1, 1'b0, 16'd0, 8'h00, 1'b0, 8'h00, 16'd2, 1'b0, 8'h00, 1'b0, 16'd0, 1'b0, 16'd0},
    '{1'b1, 1'b0, 16'd0, 8'h00, 1'b0, 8'h00, 16'd3, 1'b0, 8'h00, 1'b0, 16'd0, 1'b0, 16'd0},
    '{1'b0, 1'b0, 16'd0, 8'h00, 1'b1, 8'hA1, 16'd3, 1'b0, 8'h00, 1'b0, 16'd0, 1'b1, 16'd3},
    '{1'b0, 1'b1, 16'd5, 8'h50, 1'b0, 8'h00, 16'd3, 1'b0, 8'h00, 1'b0, 16'd0, 1'b0, 16'd0},
    '{1'b0, 1'b1, 16'd3, 8'h30, 1'b0, 8'h00, 16'd3, 1'b0, 8'h00, 1'b0, 16'd0, 1'b0, 16'd0},
    '{1'b0, 1'b0, 16'd0, 8'h00, 1'b0, 8'h00, 16'd3, 1'b1, 8'h30, 1'b0, 16'd0, 1'b0, 16'd0},
    '{1'b1, 1'b0, 16'd0, 8'h00, 1'b0, 8'h00, 16'd4, 1'b0, 8'h00, 1'b0, 16'd0, 1'b0, 16'd0},
    '{1'b1, 1'b0, 16'd0, 8'h00, 1'b0, 8'h00, 16'd5, 1'b0, 8'h00, 1'b0, 16'd0, 1'b0, 16'd0},
    '{1'b0, 1'b0, 16'd0, 8'h00, 1'b0, 8'h00, 16'd5, 1'b1, 8'h50, 1'b0, 16'd0, 1'b0, 16'd0},
    '{1'b0, 1'b1, 16'd2, 8'h20, 1'b0, 8'h00, 16'd2, 1'b0, 8'h00, 1'b1, 16'd2, 1'b0, 16'd0},
    '{1'b0, 1'b0, 16'd0, 8'h00, 1'b0, 8'h00, 16'd2, 1'b1, 8'h20, 1'b0, 16'd0, 1'b0, 16'd0},
    '{1'b1, 1'b0, 16'd0, 8'h00, 1'b1, 8'hB2, 16'd3, 1'b0, 8'h00, 1'b0, 16'd0, 1'b1, 16'd2}
  };

  initial begin
    logic [7:0] got [16];
    int         n;
    logic [7:0] exp_full [8];
    logic [7:0] full_st  [8];

    // R1: reset state
    do_reset();
    chk("R1 lvt", 32'(lvt), 32'd0);
    chk("R1 inv_valid", 32'(inv_v), 32'd0);
    chk("R1 rb_valid", 32'(rb_v), 32'd0);
    chk("R1 out_valid", 32'(out_v), 32'd0);
    chk("R1 in_ready", 32'(in_rdy), 32'd1);

    // Vector walk: R2 advance, R3 local stamps, R4 stale, R5 equal, R6 future
    for (int k = 0; k < 13; k++) begin
      step(VECS[k].adv, VECS[k].iv, VECS[k].is, 32'(VECS[k].ia), VECS[k].lw, 32'(VECS[k].la));
      chk("R2 lvt", 32'(lvt), 32'(VECS[k].e_lvt));
      chk("R6 inv_valid", 32'(inv_v), 32'(VECS[k].e_inv));
      if (VECS[k].e_inv) chk("R5 inv_addr", inv_a, 32'(VECS[k].e_inva));
      chk("R4 rb_valid", 32'(rb_v), 32'(VECS[k].e_rb));
      if (VECS[k].e_rb) chk("R4 rb_stamp", 32'(rb_s), 32'(VECS[k].e_rbs));
      chk("R3 out_valid", 32'(out_v), 32'(VECS[k].e_out));
      if (VECS[k].e_out) begin
        chk("R3 out_stamp", 32'(out_s), 32'(VECS[k].e_outs));
        chk("R3 out_addr", out_a, 32'(VECS[k].la));
      end
    end

    // R8 / R7: fill 8 slots at time 0, offer a ninth, then drain in order
    do_reset();
    full_st = '{8'd4, 8'd2, 8'd4, 8'd1, 8'd3, 8'd2, 8'd1, 8'd3};
    for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 16'(full_st[k]), 32'h10 + 32'(k), 1'b0, '0);
    chk("R8 ready low when full", 32'(in_rdy), 32'd0);
    step(1'b0, 1'b1, 16'd1, 32'hFF, 1'b0, '0);   // dropped: R8
    chk("R8 no issue at time 0", 32'(inv_v), 32'd0);
    exp_full = '{8'h13, 8'h16, 8'h11, 8'h15, 8'h14, 8'h17, 8'h10, 8'h12};
    n = 0;
    for (int k = 0; k < 20; k++) begin
      step(1'b1, 1'b0, '0, '0, 1'b0, '0);
      if (inv_v) begin
        if (n < 16) got[n] = inv_a[7:0];
        n++;
      end
    end
    chk("R8 exactly eight issued", 32'(n), 32'd8);
    for (int k = 0; k < 8; k++) chk("R7 release order", 32'(got[k]), 32'(exp_full[k]));
    chk("R8 ready after drain", 32'(in_rdy), 32'd1);

    // R9 / R4: rollback with future entries pending and adv high together
    do_reset();
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, '0, '0, 1'b0, '0);
    step(1'b0, 1'b1, 16'd9, 32'h90, 1'b0, '0);
    step(1'b0, 1'b1, 16'd7, 32'h70, 1'b0, '0);
    step(1'b1, 1'b1, 16'd2, 32'h22, 1'b0, '0);
    chk("R4 rollback beats advance", 32'(lvt), 32'd2);
    chk("R4 rb pulse", 32'(rb_v), 32'd1);
    chk("R4 rb stamp", 32'(rb_s), 32'd2);
    step(1'b0, 1'b0, '0, '0, 1'b0, '0);
    chk("R4 rb pulse ends", 32'(rb_v), 32'd0);
    chk("R4 stale message issued", 32'(inv_v), 32'd1);
    chk("R4 stale address", inv_a, 32'h22);
    n = 0;
    for (int k = 0; k < 12; k++) begin
      step(1'b1, 1'b0, '0, '0, 1'b0, '0);
      if (inv_v) begin
        if (n < 16) got[n] = inv_a[7:0];
        n++;
      end
    end
    chk("R9 entries kept", 32'(n), 32'd2);
    chk("R9 first kept", 32'(got[0]), 32'h70);
    chk("R9 second kept", 32'(got[1]), 32'h90);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule